// File: doc/BRIEF.md
# NAND Invalid-Block Table Builder

After reset this block walks every erase block of an attached NAND flash device, from block 0 up to the last one, and records which blocks are unusable. For each block it reads the factory marker in the spare area of the first page and, if that marker is clean, of the second page too. A block is recorded as invalid when either marker differs from the erased value. The marker sits just past the main data area, so its column depends on the bus width. The result is a one-bit-per-block table, held in flops, that neighbouring logic reads through a query port with one cycle of latency.

The block does not drive flash pins. It issues cycle requests (command, address or data read) on a valid/ready request stream. A pin-level sequencer takes those requests and returns the read word on a valid/ready response stream. The block watches the device's ready/busy line directly. It raises a done flag when the walk ends. If the device stays busy too long it stops the walk and sets an error flag.

Back-pressure rules: a request is offered with `cyc_valid` and completes on the first rising edge where `cyc_ready` is also high. While it waits, its kind and data stay unchanged. The block never offers a request while the device reports busy. `rd_ready` is high only while a read word is awaited, and a word completes when `rd_valid` and `rd_ready` are both high.

Top module: `nand_bbt_scanner`

## Requirements
- R1: After reset the walk starts at block 0 and moves up one block at a time, reading page 0 and then, if needed, page 1 of each block. `scan_done` rises the cycle after the last block's bit is written and stays high until reset.
- R2: Every page read is this request sequence: command 00h, five address cycles, command 30h, a wait for the device to go busy and then ready, and one data read request. Request kind codes on `cyc_kind` are 0 for command, 1 for address and 2 for data read.
- R3: The address cycles carry, in this order, column bits 7:0, column bits 15:8, then row bits 7:0, 15:8 and 23:16. The row is block × PAGES_PER_BLOCK + page. The column is 2048 when BUS16 = 0 and 1024 when BUS16 = 1. Command and address requests carry zero in `cyc_data[15:8]`.
- R4: With BUS16 = 0 a marker is clean only if `rd_data[7:0]` is FFh, and `rd_data[15:8]` is ignored. With BUS16 = 1 a marker is clean only if `rd_data` is FFFFh.
- R5: A block is recorded as bad (table bit 1) if either page's marker is not clean. When the page 0 marker is not clean, page 1 is not read.
- R6: Block 0 always reads back as good (0), whatever its markers hold.
- R7: No request is offered while `nand_rb` is low (busy). After command 30h the block waits for `nand_rb` to go low and then high again before it requests the data read.
- R8: An offered request keeps its kind and data until it is accepted. `rd_ready` is never high while a request is offered.
- R9: `q_bad` gives the table bit of the block that was on `q_blk` at the previous rising edge. A bit written on that same edge is not yet visible. An index past the last block reads 0.
- R10: If `nand_rb` does not complete its low-then-high sequence within BUSY_TIMEOUT cycles after command 30h, `scan_error` and `scan_done` go high. No request is offered after that, and blocks not yet reached read as good.
- R11: Reset clears the table, `scan_done` and `scan_error`, and starts a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; release starts a walk |
| cyc_valid | output | 1 | Request offered |
| cyc_ready | input | 1 | Sequencer accepts the request |
| cyc_kind | output | 2 | 0 command, 1 address, 2 data read |
| cyc_data | output | 16 | Command or address byte in bits 7:0 |
| nand_rb | input | 1 | Device ready (1) or busy (0) |
| rd_valid | input | 1 | Read word available |
| rd_ready | output | 1 | Block waits for a read word |
| rd_data | input | 16 | Read word |
| q_blk | input | IDX_W = clog2(NUM_BLOCKS) | Block index to query |
| q_bad | output | 1 | Table bit of the queried block, one cycle later |
| scan_done | output | 1 | Walk finished (or aborted) |
| scan_error | output | 1 | Walk aborted on busy timeout |

## Verification
The two functions that can land in the same cycle are a table write at the end of a block and a query of that same block. The bench issues a random query on every cycle of every walk, so it hits these collisions many times. During the walk each answer must be either 0 (the write is not yet visible) or the block's final value, and once the walk is done every answer must equal the final value exactly. Two device models, one 8-bit and one 16-bit, add random request stalls, random busy lengths and random marker words, so busy phases and stalled requests also overlap with queries.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_ADDR = 2'd1;
  localparam logic [1:0] KIND_READ = 2'd2;

  localparam logic [7:0] OP_READ_SETUP = 8'h00;
  localparam logic [7:0] OP_READ_GO    = 8'h30;

  localparam int ROW_W = 24;

  typedef enum logic [2:0] {
    PR_IDLE, PR_ISSUE, PR_WAIT_LOW, PR_WAIT_HIGH, PR_RD_REQ, PR_RD_DATA
  } pr_state_e;

  typedef enum logic [1:0] {
    SC_LAUNCH, SC_WAIT, SC_END
  } sc_state_e;
endpackage

// File: rtl/nbs_busy_timer.sv
module nbs_busy_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LIM);
endmodule

// File: rtl/nbs_marker_check.sv
module nbs_marker_check #(
  parameter bit BUS16 = 1'b0
) (
  input  logic [15:0] word,
  output logic        dirty
);
  localparam logic [15:0] IGNORE = BUS16 ? 16'h0000 : 16'hFF00;
  assign dirty = (word | IGNORE) != 16'hFFFF;
endmodule

// File: rtl/nbs_page_reader.sv
module nbs_page_reader
  import nbs_pkg::*;
#(
  parameter bit BUS16        = 1'b0,
  parameter int BUSY_TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row_in,
  output logic             cyc_valid,
  input  logic             cyc_ready,
  output logic [1:0]       cyc_kind,
  output logic [15:0]      cyc_data,
  input  logic             nand_rb,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [15:0]      rd_data,
  output logic             page_done,
  output logic             marker_bad,
  output logic             timed_out
);
  localparam logic [15:0] COL = BUS16 ? 16'd1024 : 16'd2048;
  localparam logic [2:0]  LAST_STEP = 3'd6;

  pr_state_e        state;
  logic [2:0]       step;
  logic [ROW_W-1:0] row_q;
  logic             expired;
  logic             word_dirty;

  nbs_busy_timer #(.LIMIT(BUSY_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == PR_WAIT_LOW || state == PR_WAIT_HIGH),
    .expired (expired)
  );

  nbs_marker_check #(.BUS16(BUS16)) u_mark (
    .word  (rd_data),
    .dirty (word_dirty)
  );

  always_comb begin
    cyc_kind = KIND_CMD;
    cyc_data = 16'h0000;
    if (state == PR_RD_REQ) begin
      cyc_kind = KIND_READ;
    end else begin
      case (step)
        3'd0: begin cyc_kind = KIND_CMD;  cyc_data = {8'h00, OP_READ_SETUP}; end
        3'd1: begin cyc_kind = KIND_ADDR; cyc_data = {8'h00, COL[7:0]};      end
        3'd2: begin cyc_kind = KIND_ADDR; cyc_data = {8'h00, COL[15:8]};     end
        3'd3: begin cyc_kind = KIND_ADDR; cyc_data = {8'h00, row_q[7:0]};    end
        3'd4: begin cyc_kind = KIND_ADDR; cyc_data = {8'h00, row_q[15:8]};   end
        3'd5: begin cyc_kind = KIND_ADDR; cyc_data = {8'h00, row_q[23:16]};  end
        default: begin cyc_kind = KIND_CMD; cyc_data = {8'h00, OP_READ_GO};  end
      endcase
    end
  end

  assign cyc_valid = (state == PR_ISSUE || state == PR_RD_REQ) && nand_rb;
  assign rd_ready  = (state == PR_RD_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PR_IDLE;
      step       <= '0;
      row_q      <= '0;
      page_done  <= 1'b0;
      marker_bad <= 1'b0;
      timed_out  <= 1'b0;
    end else begin
      page_done <= 1'b0;
      timed_out <= 1'b0;
      case (state)
        PR_IDLE: if (start) begin
          row_q <= row_in;
          step  <= '0;
          state <= PR_ISSUE;
        end
        PR_ISSUE: if (cyc_valid && cyc_ready) begin
          if (step == LAST_STEP) state <= PR_WAIT_LOW;
          else                   step  <= step + 1'b1;
        end
        PR_WAIT_LOW: begin
          if (expired) begin
            timed_out <= 1'b1;
            state     <= PR_IDLE;
          end else if (!nand_rb) begin
            state <= PR_WAIT_HIGH;
          end
        end
        PR_WAIT_HIGH: begin
          if (expired) begin
            timed_out <= 1'b1;
            state     <= PR_IDLE;
          end else if (nand_rb) begin
            state <= PR_RD_REQ;
          end
        end
        PR_RD_REQ: if (cyc_valid && cyc_ready) state <= PR_RD_DATA;
        PR_RD_DATA: if (rd_valid) begin
          marker_bad <= word_dirty;
          page_done  <= 1'b1;
          state      <= PR_IDLE;
        end
        default: state <= PR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbs_block_table.sv
module nbs_block_table #(
  parameter int NUM_BLOCKS = 64,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bad,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_bad
);
  localparam logic [IDX_W:0] COUNT = (IDX_W + 1)'(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] bits;

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
      always_ff @(posedge clk) begin
        if (!rst_n)
          bits[b] <= 1'b0;
        else if (wr_en && wr_idx == IDX_W'(b))
          bits[b] <= wr_bad;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                      q_bad <= 1'b0;
    else if ({1'b0, q_idx} < COUNT)  q_bad <= bits[q_idx];
    else                             q_bad <= 1'b0;
  end
endmodule

// File: rtl/nand_bbt_scanner.sv
module nand_bbt_scanner
  import nbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 64,
  parameter int PAGES_PER_BLOCK = 64,
  parameter bit BUS16           = 1'b0,
  parameter int BUSY_TIMEOUT    = 4096,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             cyc_valid,
  input  logic             cyc_ready,
  output logic [1:0]       cyc_kind,
  output logic [15:0]      cyc_data,
  input  logic             nand_rb,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [15:0]      rd_data,
  input  logic [IDX_W-1:0] q_blk,
  output logic             q_bad,
  output logic             scan_done,
  output logic             scan_error
);
  localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(NUM_BLOCKS - 1);

  sc_state_e        state;
  logic [IDX_W-1:0] blk;
  logic             pg;
  logic [ROW_W-1:0] row;
  logic             page_done, marker_bad, timed_out;
  logic             wr_en, wr_bad;

  assign row = ROW_W'(blk) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(pg);

  nbs_page_reader #(.BUS16(BUS16), .BUSY_TIMEOUT(BUSY_TIMEOUT)) u_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (state == SC_LAUNCH),
    .row_in     (row),
    .cyc_valid  (cyc_valid),
    .cyc_ready  (cyc_ready),
    .cyc_kind   (cyc_kind),
    .cyc_data   (cyc_data),
    .nand_rb    (nand_rb),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .page_done  (page_done),
    .marker_bad (marker_bad),
    .timed_out  (timed_out)
  );

  assign wr_en  = (state == SC_WAIT) && page_done && (pg || marker_bad);
  assign wr_bad = marker_bad && (blk != '0);

  nbs_block_table #(.NUM_BLOCKS(NUM_BLOCKS)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (blk),
    .wr_bad (wr_bad),
    .q_idx  (q_blk),
    .q_bad  (q_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SC_LAUNCH;
      blk        <= '0;
      pg         <= 1'b0;
      scan_done  <= 1'b0;
      scan_error <= 1'b0;
    end else begin
      case (state)
        SC_LAUNCH: state <= SC_WAIT;
        SC_WAIT: begin
          if (timed_out) begin
            scan_error <= 1'b1;
            scan_done  <= 1'b1;
            state      <= SC_END;
          end else if (page_done) begin
            if (!pg && !marker_bad) begin
              pg    <= 1'b1;
              state <= SC_LAUNCH;
            end else if (blk == LAST_BLK) begin
              scan_done <= 1'b1;
              state     <= SC_END;
            end else begin
              blk   <= blk + 1'b1;
              pg    <= 1'b0;
              state <= SC_LAUNCH;
            end
          end
        end
        default: state <= SC_END;
      endcase
    end
  end
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid,
  input logic             cyc_ready,
  input logic [1:0]       cyc_kind,
  input logic [15:0]      cyc_data,
  input logic             nand_rb,
  input logic             rd_ready,
  input logic [IDX_W-1:0] q_blk,
  input logic             q_bad,
  input logic             scan_done,
  input logic             scan_error
);
  // R7
  no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> nand_rb);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind != 2'd2) |-> (cyc_data[15:8] == 8'h00));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=>
      (!nand_rb || (cyc_valid && $stable(cyc_kind) && $stable(cyc_data))));

  // R8
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !cyc_valid);

  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done);

  // R10
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_error |-> scan_done);

  // R10
  quiet_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (!cyc_valid && !rd_ready));

  // R6
  blk0_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_blk == '0) |=> !q_bad);
endmodule

bind nand_bbt_scanner nbs_checker #(.IDX_W(IDX_W)) u_nbs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_valid  (cyc_valid),
  .cyc_ready  (cyc_ready),
  .cyc_kind   (cyc_kind),
  .cyc_data   (cyc_data),
  .nand_rb    (nand_rb),
  .rd_ready   (rd_ready),
  .q_blk      (q_blk),
  .q_bad      (q_bad),
  .scan_done  (scan_done),
  .scan_error (scan_error)
);

// File: tb/test_nand_bbt_scanner.sv
function automatic bit exp_bad0(int b);
  return (b == 0) || (b % 5 == 3);
endfunction

function automatic bit exp_bad1(int b);
  return (b % 7 == 2);
endfunction

function automatic bit exp_final(int b);
  return (b != 0) && (exp_bad0(b) || exp_bad1(b));
endfunction

module nbs_nand_model #(
  parameter bit BUS16 = 1'b0,
  parameter int PPB   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_valid,
  output logic        cyc_ready,
  input  logic [1:0]  cyc_kind,
  input  logic [15:0] cyc_data,
  output logic        nand_rb,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [15:0] rd_data,
  input  logic        hang_en,
  input  int          hang_blk,
  output int          seq_err,
  output int          col_err,
  output int          ord_err,
  output int          busy_err,
  output int          hold_err,
  output int          pages,
  output int          hs_cnt
);
  int step, busy_cnt, rd_wait, exp_blk, exp_pg;
  bit hang, rd_pend, prev_wait;
  logic [7:0]  ab [1:5];
  logic [15:0] marker, prev_data;
  logic [1:0]  prev_kind;

  function automatic logic [15:0] make_marker(bit bad);
    logic [7:0] junk;
    int pick;
    junk = 8'($urandom);
    pick = int'($urandom % 4);
    if (BUS16) begin
      if (!bad) return 16'hFFFF;
      case (pick)
        0: return 16'h0000;
        1: return 16'h00FF;
        2: return 16'hFF00;
        default: return 16'hFFFE;
      endcase
    end else begin
      if (!bad) return {junk, 8'hFF};
      case (pick)
        0: return {junk, 8'h00};
        1: return {junk, 8'hF0};
        2: return {junk, 8'h7F};
        default: return {junk, 8'hFE};
      endcase
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc_ready <= 1'b0; nand_rb <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      step = 0; busy_cnt = 15; rd_pend = 0; hang = 0; exp_blk = 0; exp_pg = 0;
      prev_wait = 0; seq_err <= 0; col_err <= 0; ord_err <= 0;
      busy_err <= 0; hold_err <= 0; pages <= 0; hs_cnt <= 0;
    end else begin
      if (prev_wait && nand_rb &&
          !(cyc_valid && cyc_kind == prev_kind && cyc_data == prev_data))
        hold_err <= hold_err + 1;
      prev_wait = cyc_valid && !cyc_ready;
      prev_kind = cyc_kind;
      prev_data = cyc_data;
      if (cyc_valid && cyc_ready) begin
        hs_cnt <= hs_cnt + 1;
        if (!nand_rb) busy_err <= busy_err + 1;
        if (step == 0) begin
          if (cyc_kind != 2'd0 || cyc_data != 16'h0000) seq_err <= seq_err + 1;
          step = 1;
        end else if (step <= 5) begin
          if (cyc_kind != 2'd1 || cyc_data[15:8] != 8'h00) seq_err <= seq_err + 1;
          ab[step] = cyc_data[7:0];
          step = step + 1;
        end else if (step == 6) begin
          int row, col, b, p;
          if (cyc_kind != 2'd0 || cyc_data != 16'h0030) seq_err <= seq_err + 1;
          col = int'({ab[2], ab[1]});
          row = int'({ab[5], ab[4], ab[3]});
          b = row / PPB; p = row % PPB;
          if (col != (BUS16 ? 1024 : 2048)) col_err <= col_err + 1;
          if (b != exp_blk || p != exp_pg) ord_err <= ord_err + 1;
          pages <= pages + 1;
          marker = make_marker(p == 0 ? exp_bad0(b) : exp_bad1(b));
          if (p == 0 && !exp_bad0(b)) exp_pg = 1;
          else begin exp_blk = exp_blk + 1; exp_pg = 0; end
          hang = hang_en && (b == hang_blk);
          busy_cnt = 3 + int'($urandom % 8);
          step = 7;
        end else begin
          if (cyc_kind != 2'd2) seq_err <= seq_err + 1;
          rd_pend = 1; rd_wait = int'($urandom % 3);
          step = 0;
        end
      end
      cyc_ready <= ($urandom % 3) != 0;
      if (hang) nand_rb <= 1'b0;
      else if (busy_cnt > 1) begin busy_cnt = busy_cnt - 1; nand_rb <= 1'b0; end
      else begin busy_cnt = 0; nand_rb <= 1'b1; end
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      else if (rd_pend) begin
        if (rd_wait == 0) begin
          rd_valid <= 1'b1; rd_data <= marker; rd_pend = 0;
        end else rd_wait = rd_wait - 1;
      end
    end
  end
endmodule

module test_nand_bbt_scanner;
  localparam int NB  = 24;
  localparam int PPB = 64;
  localparam int IW  = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n;
  logic hang_en;
  int   hang_blk;
  int   checks = 0, fails = 0;

  logic cv_a, cr_a, rb_a, rv_a, rr_a, qbad_a, done_a, err_a;
  logic [1:0] ck_a; logic [15:0] cd_a, rdd_a; logic [IW-1:0] q_a;
  int se_a, ce_a, oe_a, be_a, he_a, pg_a, hs_a;
  logic cv_b, cr_b, rb_b, rv_b, rr_b, qbad_b, done_b, err_b;
  logic [1:0] ck_b; logic [15:0] cd_b, rdd_b; logic [IW-1:0] q_b;
  int se_b, ce_b, oe_b, be_b, he_b, pg_b, hs_b;

  always #4 clk = ~clk;

  nand_bbt_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .BUS16(1'b0),
                     .BUSY_TIMEOUT(300)) i_nand_bbt_scanner (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cv_a), .cyc_ready(cr_a), .cyc_kind(ck_a),
    .cyc_data(cd_a), .nand_rb(rb_a), .rd_valid(rv_a), .rd_ready(rr_a),
    .rd_data(rdd_a), .q_blk(q_a), .q_bad(qbad_a), .scan_done(done_a),
    .scan_error(err_a));

  nbs_nand_model #(.BUS16(1'b0), .PPB(PPB)) i_model_a (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cv_a), .cyc_ready(cr_a), .cyc_kind(ck_a),
    .cyc_data(cd_a), .nand_rb(rb_a), .rd_valid(rv_a), .rd_ready(rr_a),
    .rd_data(rdd_a), .hang_en(hang_en), .hang_blk(hang_blk), .seq_err(se_a),
    .col_err(ce_a), .ord_err(oe_a), .busy_err(be_a), .hold_err(he_a),
    .pages(pg_a), .hs_cnt(hs_a));

  nand_bbt_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .BUS16(1'b1),
                     .BUSY_TIMEOUT(300)) i_nand_bbt_scanner_w16 (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cv_b), .cyc_ready(cr_b), .cyc_kind(ck_b),
    .cyc_data(cd_b), .nand_rb(rb_b), .rd_valid(rv_b), .rd_ready(rr_b),
    .rd_data(rdd_b), .q_blk(q_b), .q_bad(qbad_b), .scan_done(done_b),
    .scan_error(err_b));

  nbs_nand_model #(.BUS16(1'b1), .PPB(PPB)) i_model_b (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cv_b), .cyc_ready(cr_b), .cyc_kind(ck_b),
    .cyc_data(cd_b), .nand_rb(rb_b), .rd_valid(rv_b), .rd_ready(rr_b),
    .rd_data(rdd_b), .hang_en(hang_en), .hang_blk(hang_blk), .seq_err(se_b),
    .col_err(ce_b), .ord_err(oe_b), .busy_err(be_b), .hold_err(he_b),
    .pages(pg_b), .hs_cnt(hs_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pages(int n);
    int s = 0;
    for (int b = 0; b < n; b++) s += exp_bad0(b) ? 1 : 2;
    return s;
  endfunction

  // R9: random query every cycle while the walk runs
  task automatic run_scan();
    int pa = 0, pb = 0;
    bit have = 0;
    while (!(done_a && done_b)) begin
      @(negedge clk);
      if (have) begin
        chk(qbad_a == 1'b0 || qbad_a == exp_final(pa), "R9 x8 query during walk",
            int'(qbad_a), int'(exp_final(pa)));
        chk(qbad_b == 1'b0 || qbad_b == exp_final(pb), "R9 x16 query during walk",
            int'(qbad_b), int'(exp_final(pb)));
      end
      pa = int'($urandom % NB); pb = int'($urandom % NB);
      q_a = IW'(pa); q_b = IW'(pb); have = 1;
    end
    @(negedge clk);
  endtask

  task automatic check_table(input int upto);
    for (int b = 0; b < NB; b++) begin
      bit e;
      q_a = IW'(b); q_b = IW'(b);
      @(negedge clk);
      e = (b < upto) ? exp_final(b) : 1'b0;
      chk(qbad_a == e, b == 0 ? "R6 x8 block 0" : "R5 x8 table bit",
          int'(qbad_a), int'(e));
      chk(qbad_b == e, b == 0 ? "R6 x16 block 0" : "R4/R5 x16 table bit",
          int'(qbad_b), int'(e));
    end
  endtask

  task automatic check_protocol();
    chk(se_a == 0 && se_b == 0, "R2 request sequence", se_a + se_b, 0);
    chk(ce_a == 0 && ce_b == 0, "R3 marker column", ce_a + ce_b, 0);
    chk(oe_a == 0 && oe_b == 0, "R1 block/page order", oe_a + oe_b, 0);
    chk(be_a == 0 && be_b == 0, "R7 request while busy", be_a + be_b, 0);
    chk(he_a == 0 && he_b == 0, "R8 request held", he_a + he_b, 0);
  endtask

  initial begin
    int hs_snap_a, hs_snap_b;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; hang_en = 1'b0; hang_blk = 0; q_a = '0; q_b = '0;
    repeat (4) @(negedge clk);
    chk(!done_a && !err_a && !qbad_a, "R11 reset state x8",
        int'({done_a, err_a, qbad_a}), 0);
    chk(!done_b && !err_b && !qbad_b, "R11 reset state x16",
        int'({done_b, err_b, qbad_b}), 0);
    rst_n = 1'b1;

    run_scan();
    chk(!err_a && !err_b, "R10 no error on healthy device", int'({err_a, err_b}), 0);
    chk(pg_a == exp_pages(NB), "R5 x8 pages read (page 1 skipped)", pg_a, exp_pages(NB));
    chk(pg_b == exp_pages(NB), "R5 x16 pages read", pg_b, exp_pages(NB));
    check_protocol();
    check_table(NB);
    q_a = IW'(0); @(negedge clk);
    chk(qbad_a == 1'b0, "R6 block 0 with dirty marker", int'(qbad_a), 0);
    chk(done_a && done_b, "R1 done stays high", int'({done_a, done_b}), 3);

    // R10: device stuck busy at block 5
    rst_n = 1'b0; hang_en = 1'b1; hang_blk = 5;
    q_a = IW'(3); q_b = IW'(3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(qbad_a == 1'b0 && qbad_b == 1'b0, "R11 table cleared by reset",
        int'({qbad_a, qbad_b}), 0);
    run_scan();
    chk(err_a && err_b, "R10 timeout raises error", int'({err_a, err_b}), 3);
    hs_snap_a = hs_a; hs_snap_b = hs_b;
    check_table(5);
    repeat (50) @(negedge clk);
    chk(hs_a == hs_snap_a && hs_b == hs_snap_b, "R10 no requests after abort",
        hs_a + hs_b, hs_snap_a + hs_snap_b);
    check_protocol();

    // R11: new walk after reset
    rst_n = 1'b0; hang_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_scan();
    chk(!err_a && !err_b, "R11 rerun clears error", int'({err_a, err_b}), 0);
    check_table(NB);
    check_protocol();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule